// File: doc/BRIEF.md
# Dual-Line PDM Microphone Capture Front End

This block drives the bit clock for up to four pulse-density-modulated microphones and collects their one-bit outputs. The PDM clock comes from the system clock, which is the audio master clock. A 24.576 MHz master gives the 48 kHz rate family and a 22.5792 MHz master gives the 44.1 kHz family. A two-bit rate code divides the master by 4, 8, 16 or 32. That yields 6.144, 3.072, 1.536 or 0.768 MHz from the first master, and 5.6448, 2.8224, 1.4112 or 0.7056 MHz from the second.

Two data lines are each shared by a pair of microphones. One microphone of the pair holds its bit steady around the rising PDM clock edge, and the other holds its bit around the falling edge. A per-line polarity bit chooses which edge carries that line's primary microphone. The secondary microphone is always taken on the opposite edge. The four streams are routed to four recording channels. Each channel outputs one bit per PDM period, together with a one-cycle valid pulse. Channels 1 and 2 can be handed over to an analog path, and while handed over they stay silent. Channels 3 and 4 are always digital.

The clock generator is a three-state machine. The states are ST_IDLE, entered on reset; ST_LOW, the low half of a PDM period; and ST_HIGH, the high half. The transitions are:
- IDLE_TO_LOW, taken on the first cycle after reset, which also loads the rate code.
- LOW_TO_HIGH, taken when the low-half count expires.
- HIGH_TO_LOW, taken when the high-half count expires. This is the period boundary, and the rate code is reloaded here.

Top module: `pdm_capture_top`

## Requirements
- R1: With rate code k on `rate_cfg` (0 to 3), each PDM clock period lasts 4·2^k system cycles. The high half and the low half each last 2·2^k cycles. Code 0 is the fastest rate and code 3 the slowest.
- R2: A new `rate_cfg` value takes effect only at the falling PDM clock edge that ends a high half. The period in progress finishes at the old rate. Every period has equal high and low halves, so no shortened pulse appears.
- R3: For line l, `line_edge[l]`=0 takes the primary stream on the rising PDM clock edge, and `line_edge[l]`=1 takes it on the falling edge. The secondary stream of the line is always taken on the other edge. The two streams of one line are never valid in the same cycle.
- R4: Each data line is sampled one system cycle before the PDM clock edge that stream belongs to. The matching `ch_valid` bit is high for exactly the system cycle just before that PDM clock transition. During that cycle, `ch_bit` shows the sampled value.
- R5: The streams map to channels as follows. Line 0 primary goes to bit 0 (channel 1). Line 0 secondary goes to bit 1 (channel 2). Line 1 primary goes to bit 2 (channel 3). Line 1 secondary goes to bit 3 (channel 4).
- R6: While `ch_analog[i]` is 1 (i = 0 or 1), channel i+1 never asserts `ch_valid`, and its `ch_bit` is held at 0 from the next cycle on. Channels 3 and 4 have no such control.
- R7: Every digital channel produces exactly one valid pulse in each PDM period, and each pulse lasts a single cycle.
- R8: While `rst_n` is low, `pdm_clk`, `ch_valid` and `ch_bit` are all 0. After release, the first rising PDM clock edge occurs half a period plus one cycle after the first clock edge, using the rate code present at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_cfg | input | 2 | PDM rate code; divide ratio 4·2^code |
| line_edge | input | 2 | Per-line primary capture edge: 0 rising, 1 falling |
| ch_analog | input | 2 | Channel 1 and 2 analog select: 1 analog (silent), 0 digital |
| pdm_din | input | 2 | Shared PDM data lines |
| pdm_clk | output | 1 | Generated PDM bit clock |
| ch_bit | output | 4 | Latest captured bit per channel |
| ch_valid | output | 4 | One-cycle strobe per channel marking a new bit |

## Verification
Several properties are checked on every cycle:
- the quiet outputs during reset;
- the placement of each valid pulse just before a PDM clock transition, and its one-cycle width;
- the correct capture edge for primary and secondary streams under the live polarity bits;
- the silence of channels switched to analog;
- equal high and low halves in every period after the first.

Other behaviour only the bench scenarios can show. They measure the exact period for each rate code and a rate change in either half of a period. They compare each channel's bits with the microphone models on its assigned line, and count one pulse per period. They also check the first-edge latency after a reset.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    localparam int LINE_COUNT   = 2;
    localparam int MICS_PER_LINE = 2;
    localparam int CHAN_COUNT   = LINE_COUNT * MICS_PER_LINE;
    localparam int SWITCH_COUNT = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } pclk_state_e;

endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
    import pdm_cap_pkg::*;
#(
    parameter int RATE_W        = 2,
    parameter int MIN_HALF_LOG2 = 1,
    localparam int CNT_W        = MIN_HALF_LOG2 + (1 << RATE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_cfg,
    output logic              pdm_clk,
    output logic              pre_rise,
    output logic              pre_fall
);

    pclk_state_e       state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [RATE_W-1:0] cfg_act;
    logic [CNT_W-1:0]  half_len;
    logic              half_last;
    logic              half_pre;
    logic              pdm_clk_q;

    // Half-period length in system cycles for the active rate code
    always_comb begin
        half_len  = CNT_W'(1) << (CNT_W'(cfg_act) + CNT_W'(MIN_HALF_LOG2));
        half_last = (cnt == half_len - CNT_W'(1));
        half_pre  = (cnt == half_len - CNT_W'(2));
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = ST_LOW;                       // IDLE_TO_LOW
            ST_LOW:  if (half_last) state_nx = ST_HIGH;       // LOW_TO_HIGH
            ST_HIGH: if (half_last) state_nx = ST_LOW;        // HIGH_TO_LOW
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with phase counter and boundary-loaded rate code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            cfg_act <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) cnt <= '0;
            else                   cnt <= cnt + CNT_W'(1);
            if (state == ST_IDLE || (state == ST_HIGH && half_last))
                cfg_act <= rate_cfg;
        end
    end

    // Registered clock output, glitch free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pdm_clk_q <= 1'b0;
        else        pdm_clk_q <= (state_nx == ST_HIGH);
    end

    // Capture strobes: one system cycle ahead of the last cycle of a half
    always_comb begin
        pre_rise = (state == ST_LOW)  && half_pre;
        pre_fall = (state == ST_HIGH) && half_pre;
        pdm_clk  = pdm_clk_q;
    end

endmodule

// File: rtl/pdm_edge_demux.sv
module pdm_edge_demux (
    input  logic pre_rise,
    input  logic pre_fall,
    input  logic edge_sel,
    output logic prim_take,
    output logic sec_take
);

    // edge_sel = 0: primary on rising edge; 1: primary on falling edge
    always_comb begin
        prim_take = edge_sel ? pre_fall : pre_rise;
        sec_take  = edge_sel ? pre_rise : pre_fall;
    end

endmodule

// File: rtl/pdm_chan_route.sv
module pdm_chan_route #(
    parameter int CHANNELS   = 4,
    parameter int SWITCHABLE = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CHANNELS-1:0]   take,
    input  logic [CHANNELS-1:0]   src_bit,
    input  logic [SWITCHABLE-1:0] is_analog,
    output logic [CHANNELS-1:0]   ch_bit,
    output logic [CHANNELS-1:0]   ch_valid
);

    logic [CHANNELS-1:0] digital;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        if (c < SWITCHABLE) begin : g_switch
            assign digital[c] = ~is_analog[c];
        end else begin : g_fixed
            assign digital[c] = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_bit[c]   <= 1'b0;
                ch_valid[c] <= 1'b0;
            end else if (!digital[c]) begin
                ch_bit[c]   <= 1'b0;
                ch_valid[c] <= 1'b0;
            end else begin
                ch_valid[c] <= take[c];
                if (take[c]) ch_bit[c] <= src_bit[c];
            end
        end
    end

endmodule

// File: rtl/pdm_capture_top.sv
module pdm_capture_top
    import pdm_cap_pkg::*;
#(
    parameter int RATE_W        = 2,
    parameter int MIN_HALF_LOG2 = 1,
    parameter int LINES         = LINE_COUNT,
    parameter int SWITCHABLE    = SWITCH_COUNT,
    localparam int CHANNELS     = LINES * MICS_PER_LINE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RATE_W-1:0]     rate_cfg,
    input  logic [LINES-1:0]      line_edge,
    input  logic [SWITCHABLE-1:0] ch_analog,
    input  logic [LINES-1:0]      pdm_din,
    output logic                  pdm_clk,
    output logic [CHANNELS-1:0]   ch_bit,
    output logic [CHANNELS-1:0]   ch_valid
);

    logic                pre_rise;
    logic                pre_fall;
    logic [CHANNELS-1:0] take;
    logic [CHANNELS-1:0] src_bit;

    pdm_clkgen #(
        .RATE_W        (RATE_W),
        .MIN_HALF_LOG2 (MIN_HALF_LOG2)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_cfg (rate_cfg),
        .pdm_clk  (pdm_clk),
        .pre_rise (pre_rise),
        .pre_fall (pre_fall)
    );

    // One demux per line; primary stream to the even channel, secondary to odd
    for (genvar l = 0; l < LINES; l++) begin : g_line
        pdm_edge_demux u_demux (
            .pre_rise  (pre_rise),
            .pre_fall  (pre_fall),
            .edge_sel  (line_edge[l]),
            .prim_take (take[MICS_PER_LINE*l]),
            .sec_take  (take[MICS_PER_LINE*l+1])
        );
        assign src_bit[MICS_PER_LINE*l]   = pdm_din[l];
        assign src_bit[MICS_PER_LINE*l+1] = pdm_din[l];
    end

    pdm_chan_route #(
        .CHANNELS   (CHANNELS),
        .SWITCHABLE (SWITCHABLE)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .src_bit   (src_bit),
        .is_analog (ch_analog),
        .ch_bit    (ch_bit),
        .ch_valid  (ch_valid)
    );

endmodule

// File: rtl/pdm_capture_chk.sv
module pdm_capture_chk #(
    parameter int CHANNELS   = 4,
    parameter int SWITCHABLE = 2,
    parameter int LINES      = 2,
    parameter int SEG_W      = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pdm_clk,
    input logic [LINES-1:0]      line_edge,
    input logic [SWITCHABLE-1:0] ch_analog,
    input logic [CHANNELS-1:0]   ch_bit,
    input logic [CHANNELS-1:0]   ch_valid
);

    logic             pclk_d;
    logic [SEG_W-1:0] seg;
    logic [SEG_W-1:0] last_low;
    logic             seen_fall;
    logic             low_ok;

    // Measure the length of each clock half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_d    <= 1'b0;
            seg       <= '0;
            last_low  <= '0;
            seen_fall <= 1'b0;
            low_ok    <= 1'b0;
        end else begin
            pclk_d <= pdm_clk;
            if (pdm_clk != pclk_d) seg <= SEG_W'(1);
            else                   seg <= seg + SEG_W'(1);
            if (pdm_clk && !pclk_d) begin
                last_low <= seg;
                low_ok   <= seen_fall;
            end
            if (!pdm_clk && pclk_d) seen_fall <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!pdm_clk && ch_valid == '0 && ch_bit == '0)); // R8

    AST_VALID_BEFORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_valid) |=> (pdm_clk != $past(pdm_clk))); // R4

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pdm_clk) && low_ok) |-> (seg == last_low)); // R2

    for (genvar c = 0; c < CHANNELS; c++) begin : g_pulse
        AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[c] |=> !ch_valid[c]); // R7
    end

    for (genvar l = 0; l < LINES; l++) begin : g_edge
        AST_LINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(ch_valid[2*l] && ch_valid[2*l+1])); // R3
        AST_PRIMARY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[2*l] |-> (pdm_clk == $past(line_edge[l]))); // R3
        AST_SECONDARY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[2*l+1] |-> (pdm_clk != $past(line_edge[l]))); // R3
    end

    for (genvar c = 0; c < SWITCHABLE; c++) begin : g_analog
        AST_ANALOG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ch_analog[c]) |-> (!ch_valid[c] && !ch_bit[c])); // R6
    end

endmodule

bind pdm_capture_top pdm_capture_chk #(
    .CHANNELS   (CHANNELS),
    .SWITCHABLE (SWITCHABLE),
    .LINES      (LINES),
    .SEG_W      (MIN_HALF_LOG2 + (1 << RATE_W) + 2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdm_clk   (pdm_clk),
    .line_edge (line_edge),
    .ch_analog (ch_analog),
    .ch_bit    (ch_bit),
    .ch_valid  (ch_valid)
);

// File: tb/pdm_capture_top_test.sv
`timescale 1ns/1ps
module pdm_capture_top_test;

    localparam int NV   = 8;
    localparam int NPER = 4;
    // Fields: [5:4] rate code, [3:2] line_edge, [1:0] ch_analog
    localparam logic [5:0] VEC [NV] = '{
        6'b00_00_00, 6'b01_01_00, 6'b10_10_01, 6'b11_11_10,
        6'b00_11_11, 6'b01_10_00, 6'b11_00_01, 6'b10_01_11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_cfg = 2'd0;
    logic [1:0] line_edge = 2'd0;
    logic [1:0] ch_analog = 2'd0;
    logic [1:0] pdm_din = 2'd0;
    logic       pdm_clk;
    logic [3:0] ch_bit;
    logic [3:0] ch_valid;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pdm_capture_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_cfg  (rate_cfg),
        .line_edge (line_edge),
        .ch_analog (ch_analog),
        .pdm_din   (pdm_din),
        .pdm_clk   (pdm_clk),
        .ch_bit    (ch_bit),
        .ch_valid  (ch_valid)
    );

    // Monitor and microphone models
    int rise_total = 0, fall_total = 0;
    int run_len = 0, last_low = 0, last_high = 0;
    int runt_err = 0, data_err = 0, edge_err = 0, timing_err = 0;
    int vcount [4] = '{0, 0, 0, 0};
    bit seen_fall = 0, low_ok = 0, prev_any = 0;
    logic prev_clk = 1'b0;
    logic [7:0] mic_r [2] = '{8'hA5, 8'h3C};
    logic [7:0] mic_f [2] = '{8'h5E, 8'hC1};

    function automatic logic [7:0] lfsr_nx(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_clk = 1'b0; run_len = 0; seen_fall = 0; low_ok = 0; prev_any = 0;
            pdm_din = {mic_r[1][0], mic_r[0][0]};
        end else begin
            if (prev_any && pdm_clk == prev_clk) timing_err++;
            for (int c = 0; c < 4; c++) begin
                if (ch_valid[c]) begin
                    int  ln;
                    bit  on_rise;
                    ln = c / 2;
                    vcount[c]++;
                    on_rise = ((c % 2) == 0) == (line_edge[ln] == 1'b0);
                    if (pdm_clk != !on_rise) edge_err++;
                    if (ch_bit[c] != pdm_din[ln]) data_err++;
                end
            end
            prev_any = |ch_valid;
            if (pdm_clk != prev_clk) begin
                if (pdm_clk) begin
                    last_low = run_len; low_ok = seen_fall; rise_total++;
                    for (int l = 0; l < 2; l++) begin
                        mic_f[l] = lfsr_nx(mic_f[l]); pdm_din[l] = mic_f[l][0];
                    end
                end else begin
                    last_high = run_len;
                    if (low_ok && last_high != last_low) runt_err++;
                    seen_fall = 1; fall_total++;
                    for (int l = 0; l < 2; l++) begin
                        mic_r[l] = lfsr_nx(mic_r[l]); pdm_din[l] = mic_r[l][0];
                    end
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            prev_clk = pdm_clk;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise();
        int r0 = rise_total;
        do @(posedge clk); while (rise_total == r0);
    endtask

    task automatic wait_fall();
        int f0 = fall_total;
        do @(posedge clk); while (fall_total == f0);
    endtask

    task automatic apply_cfg(input logic [5:0] v);
        do begin @(posedge clk); #1; end while (|ch_valid);
        rate_cfg = v[5:4]; line_edge = v[3:2]; ch_analog = v[1:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 100000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s_v [4];
        int s_d, s_e, half, n;

        // Reset state (R8)
        repeat (4) @(negedge clk);
        chk(pdm_clk == 1'b0, "R8", "pdm_clk in reset", int'(pdm_clk), 0);
        chk(ch_valid == 4'd0 && ch_bit == 4'd0, "R8", "outputs in reset",
            int'({ch_valid, ch_bit}), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(posedge clk); n++; #1; end while (!pdm_clk);
        chk(n == 3, "R8", "first rise latency", n, 3);

        // Table of configurations
        for (int v = 0; v < NV; v++) begin
            apply_cfg(VEC[v]);
            half = 2 << VEC[v][5:4];
            wait_fall(); wait_fall(); wait_rise();
            for (int c = 0; c < 4; c++) s_v[c] = vcount[c];
            s_d = data_err; s_e = edge_err;
            repeat (NPER) wait_rise();
            chk(last_low == half, "R1", "low half", last_low, half);
            chk(last_high == half, "R1", "high half", last_high, half);
            for (int c = 0; c < 4; c++) begin
                if (c < 2 && VEC[v][c]) begin
                    chk(vcount[c] - s_v[c] == 0, "R6", "analog valid count",
                        vcount[c] - s_v[c], 0);
                    chk(ch_bit[c] == 1'b0, "R6", "analog bit", int'(ch_bit[c]), 0);
                end else begin
                    chk(vcount[c] - s_v[c] == NPER, "R7", "valid count",
                        vcount[c] - s_v[c], NPER);
                end
            end
            chk(data_err == s_d, "R5", "channel data vs line", data_err - s_d, 0);
            chk(edge_err == s_e, "R3", "capture edge", edge_err - s_e, 0);
        end

        // Rate change inside a high half (R2)
        apply_cfg(6'b11_00_00);
        wait_fall(); wait_fall();
        wait_rise();
        repeat (3) @(posedge clk);
        #1 rate_cfg = 2'd0;
        wait_fall();
        chk(last_high == 16, "R2", "high half finishes at old rate", last_high, 16);
        wait_rise();
        chk(last_low == 2, "R2", "new rate after boundary", last_low, 2);
        wait_fall();
        chk(last_high == 2, "R2", "new high half", last_high, 2);

        // Rate change inside a low half (R2)
        @(posedge clk); #1 rate_cfg = 2'd2;
        wait_rise();
        chk(last_low == 2, "R2", "low half keeps old rate", last_low, 2);
        wait_fall();
        chk(last_high == 2, "R2", "high half keeps old rate", last_high, 2);
        wait_rise();
        chk(last_low == 8, "R2", "next period at new rate", last_low, 8);
        chk(runt_err == 0, "R2", "unequal halves", runt_err, 0);

        // Reset in mid-run (R8)
        rate_cfg = 2'd0;
        @(posedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        chk(pdm_clk == 1'b0 && ch_valid == 4'd0 && ch_bit == 4'd0, "R8",
            "outputs after mid-run reset", int'({pdm_clk, ch_valid, ch_bit}), 0);
        @(negedge clk); rst_n = 1'b1;
        n = 0;
        do begin @(posedge clk); n++; #1; end while (!pdm_clk);
        chk(n == 3, "R8", "first rise after second reset", n, 3);

        repeat (40) @(posedge clk);
        chk(timing_err == 0, "R4", "valid not followed by clock edge", timing_err, 0);
        chk(data_err == 0, "R4", "sampled bit mismatch", data_err, 0);
        chk(edge_err == 0, "R3", "wrong capture edge total", edge_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule